// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the address stream for a four-beat burst into a synchronous burst memory. A one-cycle load strobe captures a starting address and the ordering choice. After that, every clock with the advance input high steps the two lowest address bits to the next beat. The upper address bits stay at the loaded value for as long as the burst runs.

Two orderings are available. Linear ordering counts upward from the starting value and wraps modulo four. Interleaved ordering forms each beat as the starting value XOR the beat number. When four beats have gone by, the sequence comes back to the starting address on the next advance and then repeats. The ordering is latched together with the address, so a change on the select input during a burst has no effect until the next load.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, and until the first load, `beat_valid_o` is 0 and `addr_o` is all zeros. An advance pulse in this state leaves both unchanged.
- R2: A clock with `load_i` high makes `addr_o` equal to `start_addr_i` and `beat_valid_o` equal to 1 from the next cycle onward. This is beat 0.
- R3: With `order_sel_i` = 0 at load (linear), each advance sets `addr_o[1:0]` to the value of the previous beat plus 1, modulo 4.
- R4: With `order_sel_i` = 1 at load (interleaved), beat k has `addr_o[1:0]` = start[1:0] XOR k, for k = 0..3. A start of 01 gives 01, 00, 11, 10.
- R5: The fourth advance after a load returns `addr_o[1:0]` to the starting value, and the sequence then repeats.
- R6: On a clock with both `advance_i` and `load_i` low, `addr_o` holds its value.
- R7: When `load_i` and `advance_i` are high in the same clock, the load wins. The next cycle shows beat 0 of the new start address.
- R8: `addr_o` bits above bit 1 equal the loaded value for every beat of the burst.
- R9: `order_sel_i` is sampled only on load clocks. A change on it between loads does not alter the ordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Capture the start address and ordering, and restart at beat 0 |
| advance_i | input | 1 | Step to the next beat on this clock |
| order_sel_i | input | 1 | 0 selects linear ordering, 1 selects interleaved (XOR) ordering |
| start_addr_i | input | ADDR_W | Starting address of the burst |
| addr_o | output | ADDR_W | Current beat address |
| beat_valid_o | output | 1 | High once a burst has been loaded |

## Verification
The hardest case to reach is a burst whose ordering input changes after the load while the beats are still advancing. A second hard case is a load and an advance landing on the same clock. The stimulus reaches both directly. It toggles the select input between advances of a loaded interleaved burst, and it issues a load with advance still held high in the middle of a running burst. Every start value in both orderings is then walked through five advances, so the wrap back to the starting value is observed for all eight combinations.

// File: rtl/bseq_pkg.sv
// Package: shared types and the beat-to-address mapping function for the
// burst address sequence generator. Assumes a fixed four-beat burst.
package bseq_pkg;
    localparam int BEAT_W = 2;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;

    // Map the start value and the beat number to the low address bits.
    function automatic logic [BEAT_W-1:0] beat_low(
        input logic [BEAT_W-1:0] start_lo,
        input logic [BEAT_W-1:0] beat,
        input order_e            order
    );
        logic [BEAT_W-1:0] res;
        if (order == ORD_XOR) res = start_lo ^ beat;
        else                  res = start_lo + beat;
        return res;
    endfunction
endpackage

// File: rtl/bseq_beat_ctr.sv
// Beat counter: keeps the beat number of the current burst and the valid
// flag. A load restarts at beat 0 and takes priority over advance. An
// advance only counts once a burst has been loaded. The counter is
// BEAT_W bits wide, so it wraps naturally after the last beat.
module bseq_beat_ctr
    import bseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    output logic [BEAT_W-1:0] beat,
    output logic              valid
);
    // Purpose: update the beat number and the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat  <= '0;
            valid <= 1'b0;
        end else if (load) begin
            beat  <= '0;
            valid <= 1'b1;
        end else if (advance && valid) begin
            beat  <= beat + 1'b1;
        end
    end
endmodule

// File: rtl/bseq_base_hold.sv
// Base holder: captures the starting address and the ordering mode on a
// load and keeps both until the next load. Assumes that order_sel is only
// meaningful on load clocks.
module bseq_base_hold
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] base,
    output order_e            order
);
    // Purpose: latch the address and the ordering on a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base  <= '0;
            order <= ORD_LINEAR;
        end else if (load) begin
            base  <= start_addr;
            order <= order_e'(order_sel);
        end
    end
endmodule

// File: rtl/bseq_low_map.sv
// Low-bit mapper: combinational translation of the start low bits and the
// beat number into the current low address bits, for the latched ordering.
module bseq_low_map
    import bseq_pkg::*;
(
    input  logic [BEAT_W-1:0] start_lo,
    input  logic [BEAT_W-1:0] beat,
    input  order_e            order,
    output logic [BEAT_W-1:0] addr_lo
);
    // Purpose: apply the ordering function.
    always_comb begin
        addr_lo = beat_low(start_lo, beat, order);
    end
endmodule

// File: rtl/burst_addr_seq.sv
// Top: four-beat burst address sequence generator. The upper address bits
// come from the loaded base. The lowest BEAT_W bits follow a linear or an
// interleaved order. Assumes ADDR_W > BEAT_W.
module burst_addr_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              advance_i,
    input  logic              order_sel_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              beat_valid_o
);
    localparam int HI_W = ADDR_W - BEAT_W;

    logic [BEAT_W-1:0] beat;
    logic [ADDR_W-1:0] base;
    order_e            order;
    logic [BEAT_W-1:0] addr_lo;

    bseq_beat_ctr u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_i),
        .advance (advance_i),
        .beat    (beat),
        .valid   (beat_valid_o)
    );

    bseq_base_hold #(.ADDR_W(ADDR_W)) u_base (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load_i),
        .start_addr (start_addr_i),
        .order_sel  (order_sel_i),
        .base       (base),
        .order      (order)
    );

    bseq_low_map u_map (
        .start_lo (base[BEAT_W-1:0]),
        .beat     (beat),
        .order    (order),
        .addr_lo  (addr_lo)
    );

    // Purpose: join the held upper bits with the mapped low bits.
    always_comb begin
        addr_o = {base[ADDR_W-1 -: HI_W], addr_lo};
    end
endmodule

// File: rtl/bseq_checker.sv
// Checker: temporal properties of the burst address generator, observed at
// its ports. Keeps its own record of the loaded start value, the ordering
// and the number of advances.
module bseq_checker #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_i,
    input logic              advance_i,
    input logic              order_sel_i,
    input logic [ADDR_W-1:0] start_addr_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              beat_valid_o
);
    logic       chk_mode;
    logic [1:0] chk_start;
    logic [1:0] chk_cnt;
    logic [1:0] chk_lin;

    // Purpose: record what the ports imply about the running burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_mode  <= 1'b0;
            chk_start <= 2'b00;
            chk_cnt   <= 2'b00;
        end else if (load_i) begin
            chk_mode  <= order_sel_i;
            chk_start <= start_addr_i[1:0];
            chk_cnt   <= 2'b00;
        end else if (advance_i && beat_valid_o) begin
            chk_cnt   <= chk_cnt + 2'b01;
        end
    end

    assign chk_lin = chk_start + chk_cnt;

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!beat_valid_o && addr_o == '0));

    assert_load_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (beat_valid_o && addr_o == $past(start_addr_i)));

    assert_linear_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && !chk_mode) |-> addr_o[1:0] == chk_lin);

    assert_xor_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && chk_mode) |-> addr_o[1:0] == (chk_start ^ chk_cnt));

    assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && advance_i && !load_i && chk_cnt == 2'd3)
        |=> addr_o[1:0] == $past(chk_start));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !advance_i) |=> $stable(addr_o));

    assert_upper_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> addr_o[ADDR_W-1:2] == $past(addr_o[ADDR_W-1:2]));
endmodule

bind burst_addr_seq bseq_checker #(.ADDR_W(ADDR_W)) u_bseq_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_i),
    .advance_i    (advance_i),
    .order_sel_i  (order_sel_i),
    .start_addr_i (start_addr_i),
    .addr_o       (addr_o),
    .beat_valid_o (beat_valid_o)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
    localparam int AW = 20;

    typedef struct {
        logic [AW-1:0] addr;
        logic          valid;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_i = 1'b0;
    logic          advance_i = 1'b0;
    logic          order_sel_i = 1'b0;
    logic [AW-1:0] start_addr_i = '0;
    logic [AW-1:0] addr_o;
    logic          beat_valid_o;

    int total = 0;
    int bad = 0;
    exp_t q[$];

    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_idx = 2'b00;
    logic          m_mode = 1'b0;
    logic          m_valid = 1'b0;

    always #10 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) i_burst_addr_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load_i),
        .advance_i    (advance_i),
        .order_sel_i  (order_sel_i),
        .start_addr_i (start_addr_i),
        .addr_o       (addr_o),
        .beat_valid_o (beat_valid_o)
    );

    function automatic logic [AW-1:0] model_addr();
        logic [1:0] lo;
        if (!m_valid) return '0;
        lo = m_mode ? (m_base[1:0] ^ m_idx) : (m_base[1:0] + m_idx);
        return {m_base[AW-1:2], lo};
    endfunction

    // Driver: apply one clock of stimulus and queue the expected result.
    task automatic step(input logic ld, input logic adv, input logic [AW-1:0] a,
                        input logic sel, input string tag);
        exp_t e;
        @(negedge clk);
        load_i = ld; advance_i = adv; start_addr_i = a; order_sel_i = sel;
        if (ld) begin
            m_base = a; m_idx = 2'b00; m_mode = sel; m_valid = 1'b1;
        end else if (adv && m_valid) begin
            m_idx = m_idx + 2'b01;
        end
        e.addr = model_addr(); e.valid = m_valid; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare each queued item 5 ns after the edge that produced it.
    always @(posedge clk) begin
        #5;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (addr_o !== e.addr || beat_valid_o !== e.valid) begin
                bad++;
                $display("FAIL %s: addr=%h valid=%b expected addr=%h valid=%b",
                         e.tag, addr_o, beat_valid_o, e.addr, e.valid);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: state while reset is held
        repeat (2) @(posedge clk);
        #5;
        total++;
        if (beat_valid_o !== 1'b0 || addr_o !== '0) begin
            bad++;
            $display("FAIL R1: addr=%h valid=%b expected addr=0 valid=0", addr_o, beat_valid_o);
        end
        @(negedge clk); rst_n = 1'b1;
        // R1: an advance before any load is ignored
        step(0, 1, 20'h12345, 0, "R1");
        step(0, 0, 20'h12345, 0, "R1");
        // R2, R3, R5, R8: linear burst from low bits 01
        step(1, 0, 20'hABCD1, 0, "R2");
        step(0, 1, 20'h00000, 1, "R3");
        step(0, 1, 20'h00000, 0, "R3");
        step(0, 1, 20'h00000, 0, "R8");
        step(0, 1, 20'h00000, 0, "R5");
        step(0, 1, 20'h00000, 0, "R5");
        // R4: interleaved burst from low bits 01 -> 01,00,11,10
        step(1, 0, 20'h55551, 1, "R2");
        step(0, 1, 20'h0, 1, "R4");
        // R6: no advance holds the address
        step(0, 0, 20'h0, 1, "R6");
        step(0, 0, 20'hFFFFF, 0, "R6");
        // R9: select toggles mid-burst without effect
        step(0, 1, 20'h0, 0, "R9");
        step(0, 1, 20'h0, 1, "R9");
        step(0, 1, 20'h0, 0, "R9");
        // R7: load with advance held lands on beat 0
        step(0, 1, 20'h0, 0, "R4");
        step(1, 1, 20'h3C3C2, 0, "R7");
        step(1, 1, 20'h0F0F3, 1, "R7");
        step(0, 1, 20'h0, 0, "R4");
        // R3, R4, R5: every start value in both orderings
        for (int s = 0; s < 4; s++) begin
            for (int m = 0; m < 2; m++) begin
                step(1, 0, {18'h2A5A5, 2'(s)}, 1'(m), "R2");
                for (int k = 0; k < 5; k++)
                    step(0, 1, 20'h0, 1'(~m), (k == 4) ? "R5" : (m == 1 ? "R4" : "R3"));
            end
        end
        step(0, 0, 20'h0, 0, "R6");
        repeat (3) @(posedge clk);
        #8;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule